// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sequences the conversions of an analog-to-digital converter. Software reaches it through a single 7-bit control word. The word holds an enable bit, a start bit, a free-running bit, an interrupt flag and a 3-bit clock divider select. The block does not touch the analog path. When a conversion begins, it announces the current channel selection on a one-cycle trigger output. It then times the conversion in divided converter clocks. On completion it latches the sample presented on its data input and raises the interrupt flag.

The converter clock period is 2^n system clocks, where n is the divider select and a select of 0 acts as 1. The first conversion after the enable bit rises takes 25 converter clocks. Every later conversion takes 13. Once the start bit is set, software cannot clear it. Only completion or dropping the enable bit clears it. In free-running mode, each completion immediately launches the next conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control readback, the interrupt flag, the trigger pulse, the trigger channel and the result are all zero.
- R2: The control word layout is: bit 6 enable, bit 5 start, bit 4 free-running, bit 3 flag (read) or flag clear (write 1), bits 2:0 divider select n. One converter clock lasts 2^n system clocks, and n = 0 gives the same period as n = 1.
- R3: A conversion that is the first after the enable bit goes from 0 to 1 lasts 25 converter clocks. Any other conversion lasts 13. The flag is first seen set exactly len·2^n clocks after the write that started the conversion.
- R4: A write that takes the start bit from 0 to 1 while enabled pulses `trig_valid` for one cycle in the cycle after the write, with `trig_chan` equal to `chan_sel` at the write.
- R5: Writing 0 to the start bit during a conversion leaves it set. Writing 1 again during a conversion neither retriggers nor changes its completion time.
- R6: Clearing the enable bit aborts a running conversion and clears the start bit, and that conversion never raises the flag.
- R7: On completion, the flag is set, the start bit is cleared, and `result` takes `sample_in`, all at the same clock edge.
- R8: With free-running set, completion keeps the start bit set, pulses the trigger with the current channel, and starts a 13-clock conversion at once.
- R9: Writing 1 to bit 3 clears the flag. If completion falls in the same cycle as the clear, the flag stays set.
- R10: A write that sets the start bit while the enable bit is written 0 is ignored: start stays 0 and no trigger is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word write data |
| ctl_rdata | output | 7 | Control word readback |
| chan_sel | input | MUX_W | Channel selection to publish at start |
| sample_in | input | RES_W | Converted value captured at completion |
| trig_valid | output | 1 | One-cycle pulse when a conversion begins |
| trig_chan | output | MUX_W | Channel published with the trigger |
| irq | output | 1 | Interrupt flag |
| result | output | RES_W | Latched conversion result |

## Verification
A wrong divider count or conversion length appears only as a flag that rises early or late. The bench therefore counts cycles from the starting write to the flag and compares the count exactly. A stale first-conversion mark shifts the count by 12·2^n cycles. A start bit that clears wrongly shows up at once in the readback and in a missing free-running trigger. The abort and clear-collision cases are placed on exact cycles, so that a missed abort surfaces as a flag within one conversion time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SEL_W  = 3;
    localparam int CTL_W  = 4 + SEL_W;

    typedef struct packed {
        logic             en;
        logic             start;
        logic             freerun;
        logic             flag;
        logic [SEL_W-1:0] sel;
    } ctl_word_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int CNT_W = 2 ** SW;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SW-1:0]    shift;
    logic [CNT_W-1:0] lim;

    always_comb begin
        shift = (sel == '0) ? SW'(1) : sel;
        lim   = (CNT_W'(1) << shift) - CNT_W'(1);
        tick  = run && (cnt_q >= lim);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_div_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> cnt_q == '0);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int SHORT_LEN = 13,
    parameter int LONG_LEN  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic first,
    output logic done
);
    localparam int LEN_W = $clog2(LONG_LEN + 1);

    logic [LEN_W-1:0] tcnt_d, tcnt_q;
    logic [LEN_W-1:0] last;

    always_comb begin
        last   = first ? LEN_W'(LONG_LEN - 1) : LEN_W'(SHORT_LEN - 1);
        done   = run && tick && (tcnt_q == last);
        tcnt_d = tcnt_q;
        if (!run)
            tcnt_d = '0;
        else if (done)
            tcnt_d = '0;
        else if (tick)
            tcnt_d = tcnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tcnt_q <= '0;
        else        tcnt_q <= tcnt_d;
    end

    assert_len_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> tcnt_q == '0);

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt_q <= LEN_W'(LONG_LEN - 1));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int MUX_W     = 4,
    parameter int RES_W     = 10,
    parameter int SHORT_LEN = 13,
    parameter int LONG_LEN  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic [MUX_W-1:0] chan_sel,
    input  logic [RES_W-1:0] sample_in,
    output logic             trig_valid,
    output logic [MUX_W-1:0] trig_chan,
    output logic             irq,
    output logic [RES_W-1:0] result
);
    typedef struct packed {
        logic             en;
        logic             start;
        logic             freerun;
        logic             flag;
        logic [SEL_W-1:0] sel;
        logic             first;
        logic             trig;
        logic [MUX_W-1:0] chan;
        logic [RES_W-1:0] res;
    } seq_state_t;

    seq_state_t st_d, st_q;
    ctl_word_t  wr;
    logic       tick, done;
    logic       en_nx, en_fall, en_rise, start_req, cmpl;

    adc_clk_div #(.SW(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.start),
        .sel   (st_q.sel),
        .tick  (tick)
    );

    adc_conv_timer #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.start),
        .tick  (tick),
        .first (st_q.first),
        .done  (done)
    );

    always_comb begin
        wr        = ctl_word_t'(ctl_wdata);
        en_nx     = ctl_we ? wr.en : st_q.en;
        en_fall   = st_q.en && !en_nx;
        en_rise   = !st_q.en && en_nx;
        cmpl      = done && en_nx;
        start_req = ctl_we && wr.start && !st_q.start && en_nx;

        st_d      = st_q;
        st_d.en   = en_nx;
        st_d.trig = 1'b0;
        if (ctl_we) begin
            st_d.freerun = wr.freerun;
            st_d.sel     = wr.sel;
        end

        if (en_fall || !en_nx)
            st_d.start = 1'b0;
        else if (cmpl)
            st_d.start = st_q.freerun;
        else if (start_req)
            st_d.start = 1'b1;

        if (en_rise)
            st_d.first = 1'b1;
        else if (cmpl)
            st_d.first = 1'b0;

        if (start_req || (cmpl && st_q.freerun)) begin
            st_d.trig = 1'b1;
            st_d.chan = chan_sel;
        end

        if (cmpl) begin
            st_d.flag = 1'b1;
            st_d.res  = sample_in;
        end else if (ctl_we && wr.flag) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_rdata  = {st_q.en, st_q.start, st_q.freerun, st_q.flag, st_q.sel};
    assign trig_valid = st_q.trig;
    assign trig_chan  = st_q.chan;
    assign irq        = st_q.flag;
    assign result     = st_q.res;

    assert_start_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start && !done && !(ctl_we && !wr.en)) |=> st_q.start);

    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !wr.en) |=> (!st_q.start && !st_q.trig));

    assert_trig_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (st_q.start && st_q.en));

    assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(st_q.start));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [6:0] ctl_rdata;
    logic [3:0] chan_sel = '0;
    logic [9:0] sample_in = '0;
    logic       trig_valid;
    logic [3:0] trig_chan;
    logic       irq;
    logic [9:0] result;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [6:0] EN = 7'h40, ST = 7'h20, FR = 7'h10, CLR = 7'h08;

    always #5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .chan_sel(chan_sel), .sample_in(sample_in),
        .trig_valid(trig_valid), .trig_chan(trig_chan), .irq(irq), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic measure(input int off, input int exp, input string req);
        int cnt = off;
        while (cnt < exp + 8) begin
            @(negedge clk);
            cnt++;
            if (irq) break;
        end
        chk(irq && cnt == exp, req, cnt, exp);
    endtask

    task automatic t_reset();
        chk(ctl_rdata == 0, "R1", ctl_rdata, 0);
        chk(!irq && !trig_valid, "R1", {irq, trig_valid}, 0);
        chk(result == 0 && trig_chan == 0, "R1", result, 0);
    endtask

    task automatic t_first();
        chan_sel = 4'd5; sample_in = 10'h155;
        wr(EN | ST);
        chk(trig_valid && trig_chan == 5, "R4", trig_chan, 5);
        chk(ctl_rdata[5] == 1'b1, "R4", ctl_rdata[5], 1);
        @(negedge clk);
        chk(!trig_valid, "R4", trig_valid, 0);
        measure(1, 50, "R3");
        chk(result == 10'h155, "R7", result, 10'h155);
        chk(ctl_rdata[5] == 1'b0 && ctl_rdata[3] == 1'b1, "R7", ctl_rdata, 7'h08);
    endtask

    task automatic t_div();
        wr(EN | ST | CLR | 7'd3);
        chk(!irq, "R9", irq, 0);
        measure(0, 104, "R2");
        wr(EN | ST | CLR | 7'd1);
        measure(0, 26, "R2");
        wr(EN | ST | CLR | 7'd0);
        measure(0, 26, "R2");
        wr(EN | ST | CLR | 7'd2);
        measure(0, 52, "R2");
    endtask

    task automatic t_sticky();
        wr(EN | ST | CLR);
        repeat (5) @(negedge clk);
        wr(EN);
        chk(ctl_rdata[5] == 1'b1, "R5", ctl_rdata[5], 1);
        wr(EN | ST);
        chk(!trig_valid, "R5", trig_valid, 0);
        measure(7, 26, "R5");
    endtask

    task automatic t_abort();
        wr(EN | ST | CLR);
        repeat (10) @(negedge clk);
        wr(7'h00);
        chk(ctl_rdata[5] == 1'b0, "R6", ctl_rdata[5], 0);
        repeat (60) @(negedge clk);
        chk(!irq, "R6", irq, 0);
        wr(ST);
        chk(ctl_rdata[5] == 1'b0 && !trig_valid, "R10", ctl_rdata[5], 0);
        repeat (60) @(negedge clk);
        chk(!irq, "R10", irq, 0);
        wr(EN | ST);
        measure(0, 50, "R3");
    endtask

    task automatic t_freerun();
        chan_sel = 4'd9;
        wr(EN | ST | FR | CLR);
        chk(trig_chan == 9, "R4", trig_chan, 9);
        chan_sel = 4'd3; sample_in = 10'h0F0;
        measure(0, 26, "R8");
        chk(ctl_rdata[5] == 1'b1, "R8", ctl_rdata[5], 1);
        chk(trig_valid && trig_chan == 3, "R8", trig_chan, 3);
        chk(result == 10'h0F0, "R7", result, 10'h0F0);
        sample_in = 10'h2AA;
        wr(EN | FR | CLR);
        chk(!irq && ctl_rdata[5], "R9", irq, 0);
        measure(1, 26, "R8");
        chk(result == 10'h2AA, "R8", result, 10'h2AA);
        repeat (25) @(negedge clk);
        wr(EN | FR | CLR);
        chk(irq, "R9", irq, 1);
        wr(EN | CLR);
        chk(!irq, "R9", irq, 0);
        measure(1, 26, "R8");
        chk(ctl_rdata[5] == 1'b0, "R7", ctl_rdata[5], 0);
        wr(EN | CLR);
        repeat (40) @(negedge clk);
        chk(!irq && !ctl_rdata[5], "R8", irq, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_div();
        t_sticky();
        t_abort();
        t_freerun();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule